// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the first part of a low-power SDRAM start-up. While the board reports that the supplies and the clock are not yet stable, it holds the command bus at COMMAND INHIBIT. Once the stable flag is sampled high, it counts a hard wait of `CLK_MHZ * WAIT_US` clock cycles. During that wait only NOP is driven on the bus. It then issues one PRECHARGE with address bit A10 high, so that every bank is precharged. After a parameterized precharge period it raises a done flag. That flag is the handoff to the next stage of the controller, which runs the refresh and mode-register steps.

A synchronous reset or a drop of the stable flag sends the sequencer back to its inhibit state and clears done. When the flag rises again, the full wait is counted once more. All pins are plain control and status signals. No data flows through the block, so it has no valid/ready interface and no back-pressure rules.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst` is sampled high, and in the cycle after it, `sdram_cmd` is COMMAND INHIBIT (4'b1111 as {cs_n, ras_n, cas_n, we_n}), `sdram_a10` is 0 and `init_done` is 0.
- R2: In every cycle that follows an edge at which `clk_stable` was sampled low, `sdram_cmd` is COMMAND INHIBIT, `sdram_a10` is 0 and `init_done` is 0.
- R3: The first cycle after `clk_stable` is sampled high from the inhibit state begins the wait. For exactly `CLK_MHZ * WAIT_US` consecutive cycles, `sdram_cmd` is NOP (4'b0111).
- R4: In the cycle right after the wait, `sdram_cmd` is PRECHARGE (4'b0010) for one cycle only, and the cycle before it carries a NOP.
- R5: `sdram_a10` is 1 exactly in the PRECHARGE cycle and 0 in every other cycle.
- R6: After the PRECHARGE, `TRP_CYCLES` cycles of NOP follow. In the next cycle `init_done` rises, and it stays high with NOP on the bus while `clk_stable` stays high and `rst` stays low.
- R7: If `clk_stable` drops at any point, including after done, the bus returns to INHIBIT and done clears. On reassertion the full wait is counted from the start.
- R8: One period of stable clock without reset produces at most one PRECHARGE.
- R9: A synchronous reset in the middle of the wait or the precharge period restarts the sequence exactly as a drop of `clk_stable` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock to the sequencer and to the memory |
| rst | input | 1 | Synchronous reset, active high |
| clk_stable | input | 1 | High while supplies and clock are stable |
| sdram_cmd | output | 4 | Command as {cs_n, ras_n, cas_n, we_n} |
| sdram_a10 | output | 1 | Address bit 10; high selects all banks on PRECHARGE |
| init_done | output | 1 | High once the all-bank precharge period has elapsed |

## Verification
The bench builds two instances that share one stimulus. The first uses `CLK_MHZ=4`, `WAIT_US=5`, `TRP_CYCLES=3`, which gives a 20-cycle wait. That short wait lets the bench drop the stable flag and pulse reset inside the wait, inside the precharge period and after done, many times in a short run. The second keeps the defaults (133 MHz, 100 us, 13300 cycles). This shows that the full-length counter reaches its precharge at the exact cycle, and that it ignores the disturbances aimed at the short instance, apart from restarting.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command encoding {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_INHIBIT = 4'b1111,
    CMD_NOP     = 4'b0111,
    CMD_PRECHG  = 4'b0010
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_HOLD  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_PRECH = 3'd2,
    ST_TRP   = 3'd3,
    ST_READY = 3'd4
  } init_state_e;

endpackage

// File: rtl/init_delay_cnt.sv
module init_delay_cnt #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign hit = en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (clr || hit) cnt_q <= '0;
    else if (en)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/init_seq_fsm.sv
module init_seq_fsm
  import sdram_init_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clk_stable,
  input  logic        wait_hit,
  input  logic        trp_hit,
  output init_state_e state
);
  init_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_HOLD:  state_d = ST_WAIT;
      ST_WAIT:  if (wait_hit) state_d = ST_PRECH;
      ST_PRECH: state_d = ST_TRP;
      ST_TRP:   if (trp_hit) state_d = ST_READY;
      ST_READY: state_d = ST_READY;
      default:  state_d = ST_HOLD;
    endcase
    if (!clk_stable) state_d = ST_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_HOLD;
    else     state <= state_d;
  end
endmodule

// File: rtl/init_cmd_out.sv
module init_cmd_out
  import sdram_init_pkg::*;
(
  input  init_state_e state,
  output logic [3:0]  cmd,
  output logic        a10,
  output logic        done
);
  always_comb begin
    cmd  = CMD_NOP;
    a10  = 1'b0;
    done = 1'b0;
    unique case (state)
      ST_HOLD:  cmd = CMD_INHIBIT;
      ST_PRECH: begin
        cmd = CMD_PRECHG;
        a10 = 1'b1;
      end
      ST_READY: done = 1'b1;
      default:  cmd = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 133,
  parameter int unsigned WAIT_US    = 100,
  parameter int unsigned TRP_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clk_stable,
  output logic [3:0] sdram_cmd,
  output logic       sdram_a10,
  output logic       init_done
);
  localparam int unsigned WAIT_CYCLES = CLK_MHZ * WAIT_US;
  localparam int unsigned TRP_EFF     = (TRP_CYCLES == 0) ? 1 : TRP_CYCLES;

  init_state_e state;
  logic        wait_hit;
  logic        trp_hit;

  init_seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .clk_stable (clk_stable),
    .wait_hit   (wait_hit),
    .trp_hit    (trp_hit),
    .state      (state)
  );

  init_delay_cnt #(.LIMIT(WAIT_CYCLES)) u_wait_cnt (
    .clk (clk),
    .clr (rst || state != ST_WAIT),
    .en  (state == ST_WAIT),
    .hit (wait_hit)
  );

  init_delay_cnt #(.LIMIT(TRP_EFF)) u_trp_cnt (
    .clk (clk),
    .clr (rst || state != ST_TRP),
    .en  (state == ST_TRP),
    .hit (trp_hit)
  );

  init_cmd_out u_out (
    .state (state),
    .cmd   (sdram_cmd),
    .a10   (sdram_a10),
    .done  (init_done)
  );
endmodule

// File: rtl/sdram_pwrup_chk.sv
module sdram_pwrup_chk #(
  parameter int unsigned WAIT_CYCLES = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       clk_stable,
  input logic [3:0] cmd,
  input logic       a10,
  input logic       done
);
  localparam logic [3:0] C_INH = 4'b1111;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;

  int unsigned nop_run;

  always_ff @(posedge clk) begin
    if (rst || cmd != C_NOP) nop_run <= 0;
    else if (nop_run < WAIT_CYCLES + 1) nop_run <= nop_run + 1;
  end

  AST_WAIT_LENGTH: assert property (@(posedge clk) disable iff (rst)
    cmd == C_PRE |-> nop_run == WAIT_CYCLES); // R3
  AST_PRE_AFTER_NOP: assert property (@(posedge clk) disable iff (rst)
    cmd == C_PRE |-> $past(cmd) == C_NOP); // R4
  AST_PRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cmd == C_PRE |=> cmd != C_PRE); // R8
  AST_A10_ONLY_PRE: assert property (@(posedge clk) disable iff (rst)
    a10 |-> cmd == C_PRE); // R5
  AST_DONE_NOP: assert property (@(posedge clk) disable iff (rst)
    done |-> cmd == C_NOP); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    done && clk_stable |=> done); // R6
  AST_UNSTABLE_INHIBIT: assert property (@(posedge clk) disable iff (rst)
    !clk_stable |=> cmd == C_INH && !done); // R7
endmodule

bind sdram_pwrup_seq sdram_pwrup_chk #(.WAIT_CYCLES(WAIT_CYCLES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clk_stable (clk_stable),
  .cmd        (sdram_cmd),
  .a10        (sdram_a10),
  .done       (init_done)
);

// File: tb/test_sdram_pwrup_seq.sv
module test_sdram_pwrup_seq;
  localparam int WA = 4 * 5;   // short instance wait
  localparam int TA = 3;
  localparam int WB = 133 * 100;
  localparam int TB = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_stable = 1'b0;
  logic [3:0] cmd_a, cmd_b;
  logic a10_a, a10_b, done_a, done_b;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int t_a = -1, t_b = -1;
  int pre_a = 0, pre_b = 0;
  string scen = "R1";

  always #4 clk = ~clk;

  sdram_pwrup_seq #(.CLK_MHZ(4), .WAIT_US(5), .TRP_CYCLES(TA)) i_sdram_pwrup_seq (
    .clk(clk), .rst(rst), .clk_stable(clk_stable),
    .sdram_cmd(cmd_a), .sdram_a10(a10_a), .init_done(done_a));

  sdram_pwrup_seq i_sdram_pwrup_seq_full (
    .clk(clk), .rst(rst), .clk_stable(clk_stable),
    .sdram_cmd(cmd_b), .sdram_a10(a10_b), .init_done(done_b));

  function automatic logic [5:0] expect_vec(int t, int w, int tp);
    if (t < 0)        return {4'b1111, 1'b0, 1'b0};
    if (t < w)        return {4'b0111, 1'b0, 1'b0};
    if (t == w)       return {4'b0010, 1'b1, 1'b0};
    if (t <= w + tp)  return {4'b0111, 1'b0, 1'b0};
    return {4'b0111, 1'b0, 1'b1};
  endfunction

  function automatic string phase_tag(int t, int w, int tp);
    if (t < 0)       return "R2";
    if (t < w)       return "R3";
    if (t == w)      return "R4/R5";
    return "R6";
  endfunction

  // Behavioural timeline: cycles elapsed since the stable flag was taken
  always @(posedge clk) begin
    cyc++;
    if (rst || !clk_stable) begin
      t_a = -1; t_b = -1;
    end else begin
      if (t_a < WA + TA + 1) t_a++;
      if (t_b < WB + TB + 1) t_b++;
    end
  end

  task automatic cmp(string tag, logic [5:0] got, logic [5:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s cyc=%0d got cmd=%b a10=%b done=%b exp cmd=%b a10=%b done=%b",
               tag, cyc, got[5:2], got[1], got[0], exp[5:2], exp[1], exp[0]);
    end
  endtask

  always @(negedge clk) begin
    cmp({"A ", scen, " ", phase_tag(t_a, WA, TA)}, {cmd_a, a10_a, done_a}, expect_vec(t_a, WA, TA));
    cmp({"B ", scen, " ", phase_tag(t_b, WB, TB)}, {cmd_b, a10_b, done_b}, expect_vec(t_b, WB, TB));
    if (cmd_a == 4'b0010) pre_a++;
    if (cmd_b == 4'b0010) pre_b++;
  end

  task automatic step(int n, logic r, logic s);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rst = r;
      clk_stable = s;
    end
  endtask

  task automatic check_count(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s precharge count got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  initial begin
    scen = "R1";
    step(5, 1'b1, 1'b1);          // reset dominates a high stable flag
    scen = "R2";
    step(6, 1'b0, 1'b0);
    scen = "R3";
    step(WA + TA + 12, 1'b0, 1'b1); // short instance reaches done
    check_count("R8 A first period", pre_a, 1);
    scen = "R7";
    step(2, 1'b0, 1'b0);          // drop after done
    step(12, 1'b0, 1'b1);         // mid-wait
    step(1, 1'b0, 1'b0);          // drop mid-wait
    step(WA + 2, 1'b0, 1'b1);     // just into precharge period
    scen = "R9";
    step(1, 1'b1, 1'b1);          // reset inside precharge period
    pre_a = 0; pre_b = 0;
    scen = "R8";
    step(WB + TB + 40, 1'b0, 1'b1);
    check_count("R8 A long period", pre_a, 1);
    check_count("R8 B long period", pre_b, 1);
    scen = "R7";
    step(3, 1'b0, 1'b0);          // both lose done
    step(5, 1'b0, 1'b1);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired at cyc=%0d", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule